// File: doc/BRIEF.md
# DDR SDRAM Start-Up Sequencer

This block sits on the controller side of a DDR SDRAM interface and brings the memory from power-on to an operational state. After reset is released, it holds the clock enable low for a programmable settling wait. It then raises the clock enable and spends one slot on a NOP. After that it issues the start-up commands in a fixed order: a precharge of all banks, a load of the extended mode register that enables the DLL, a load of the mode register that resets the DLL and sets burst length and CAS latency, a second precharge of all banks, two auto refreshes, and a last load of the mode register with the DLL reset bit cleared.

Each command takes a single slot. The block fills the slots that follow it with NOPs until a parameterized minimum spacing has passed: the precharge period, the mode-load period or the refresh cycle time. An independent counter starts when the DLL reset is issued. The done flag rises only after this counter has reached its lock count and the spacing after the final mode load has passed. Until then, every request from the normal traffic path is held back. The command code, bank and address outputs go straight to a command encoder.

Top module: `ddr_boot_seq`

## Requirements
- R1: While rst_n is low, cke is 0, cmd_code is NOP (0), init_done is 0 and req_grant is 0.
- R2: For the first PWRUP_CYC cycles after reset release, cke stays 0 and cmd_code stays NOP. cke then goes to 1 and never falls again until the next reset.
- R3: The cycle in which cke first reads 1 carries a NOP. The next cycle carries precharge-all: code 1, bank 0, address bit 10 set and every other address bit clear.
- R4: T_RP cycles after the first precharge-all, a mode load (code 2) goes to bank 1 with address 0. Address bit 0 clear means the DLL is enabled.
- R5: T_MRD cycles later, a mode load goes to bank 0. Its address has bit 8 set (DLL reset), bits 6:4 equal to CAS_LAT, bit 3 clear, and bits 2:0 holding the burst code (length 2 -> 1, 4 -> 2, 8 -> 3). Every other address bit is clear.
- R6: After that come a precharge-all (T_MRD later), an auto refresh (code 3, bank 0, address 0; T_RP later), a second auto refresh (T_RFC later) and a final bank-0 mode load (T_RFC later). The final mode load equals the R5 word with bit 8 clear.
- R7: Every cycle that R3 to R6 do not name carries NOP with bank 0 and address 0.
- R8: init_done rises in the first cycle after both conditions hold: at least DLL_LOCK_CYC cycles have passed since the DLL-reset load, and at least T_MRD cycles have passed since the final load. It then stays high until reset.
- R9: req_grant equals req_in while init_done is 1. Before that it is 0, whatever req_in does.
- R10: Asserting rst_n low part-way through the sequence returns cke to 0, and the whole sequence restarts from the power-up wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_in | input | 1 | Request from the normal traffic path |
| cke | output | 1 | Clock enable to the memory |
| cmd_code | output | 2 | Command: 0 NOP, 1 precharge-all, 2 mode load, 3 auto refresh |
| cmd_ba | output | 2 | Bank address for the command |
| cmd_addr | output | ADDR_W | Address / op-code for the command |
| init_done | output | 1 | Start-up sequence complete |
| req_grant | output | 1 | req_in passed through once init_done is set |

## Verification
The assertion that every command is followed by a NOP assumes T_RP, T_MRD and T_RFC are all at least 2. The lock-wait check assumes that exactly one DLL-reset load happens per reset period. The bench keeps within both assumptions because its small configuration uses spacings of 2 to 6 cycles and a single instance. The bench predicts, arithmetically and for every cycle, the command, bank, address, clock enable, done flag and grant of three runs. One of these runs is cut short by reset while cke is high. req_in is driven with a different pattern in each run, so grants are checked both before and after completion.

// File: rtl/ddr_boot_pkg.sv
`timescale 1ns/1ps
// Shared types for the DDR start-up sequencer.
// Assumes: the command encoder downstream decodes the 2-bit codes below.
package ddr_boot_pkg;

    typedef enum logic [1:0] {
        CMD_NOP  = 2'd0,
        CMD_PREA = 2'd1,
        CMD_LMR  = 2'd2,
        CMD_AREF = 2'd3
    } ddr_cmd_e;

    typedef enum logic [3:0] {
        ST_PWR,
        ST_CKE,
        ST_PRE1,
        ST_EMR,
        ST_MRR,
        ST_PRE2,
        ST_REF1,
        ST_REF2,
        ST_MRF,
        ST_LOCK,
        ST_DONE
    } boot_step_e;

    // Burst length to mode-register field code
    function automatic logic [2:0] burst_code(input int len);
        case (len)
            2:       return 3'd1;
            4:       return 3'd2;
            default: return 3'd3;
        endcase
    endfunction

endpackage

// File: rtl/boot_span_timer.sv
`timescale 1ns/1ps
// Down-counter that measures how long the current sequencer step lasts.
// Assumes: load is a single-cycle pulse at each step change; a loaded
// value of N gives expired after N more cycles.
module boot_span_timer #(
    parameter int W         = 8,
    parameter int RESET_VAL = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    // Reload on step change, otherwise count down to zero and hold
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= W'(RESET_VAL);
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/boot_lock_counter.sv
`timescale 1ns/1ps
// Counts cycles elapsed since the DLL reset command and saturates at the
// lock count.
// Assumes: start pulses once, in the cycle the DLL reset load is issued.
module boot_lock_counter #(
    parameter int LOCK_CYC = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic locked
);
    localparam int CW = $clog2(LOCK_CYC + 1);

    logic [CW-1:0] cnt_q;

    // Start at one on the issue cycle, then count until saturated
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (start)
            cnt_q <= CW'(1);
        else if (cnt_q != '0 && cnt_q != CW'(LOCK_CYC))
            cnt_q <= cnt_q + 1'b1;
    end

    assign locked = (cnt_q == CW'(LOCK_CYC));
endmodule

// File: rtl/boot_cmd_decode.sv
`timescale 1ns/1ps
// Maps the sequencer step to command, bank and address. A command is
// only issued in the first cycle of its step; other cycles are NOP.
// Assumes: ADDR_W >= 11 so the precharge-all bit exists.
module boot_cmd_decode
    import ddr_boot_pkg::*;
#(
    parameter int ADDR_W    = 13,
    parameter int BURST_LEN = 4,
    parameter int CAS_LAT   = 3
) (
    input  boot_step_e        step,
    input  logic              first,
    output ddr_cmd_e          cmd,
    output logic [1:0]        ba,
    output logic [ADDR_W-1:0] addr
);
    localparam int BIT_AP     = 10;
    localparam int BIT_DLLRST = 8;

    logic [ADDR_W-1:0] mode_word;

    // Operating parameters: burst code, sequential type, CAS latency
    always_comb begin
        mode_word      = '0;
        mode_word[2:0] = burst_code(BURST_LEN);
        mode_word[6:4] = 3'(CAS_LAT);
    end

    // Command selection for the first cycle of each step
    always_comb begin
        cmd  = CMD_NOP;
        ba   = 2'd0;
        addr = '0;
        if (first) begin
            case (step)
                ST_PRE1, ST_PRE2: begin
                    cmd          = CMD_PREA;
                    addr[BIT_AP] = 1'b1;
                end
                ST_EMR: begin
                    cmd = CMD_LMR;
                    ba  = 2'd1;
                end
                ST_MRR: begin
                    cmd              = CMD_LMR;
                    addr             = mode_word;
                    addr[BIT_DLLRST] = 1'b1;
                end
                ST_MRF: begin
                    cmd  = CMD_LMR;
                    addr = mode_word;
                end
                ST_REF1, ST_REF2: cmd = CMD_AREF;
                default: cmd = CMD_NOP;
            endcase
        end
    end
endmodule

// File: rtl/ddr_boot_seq.sv
`timescale 1ns/1ps
// DDR SDRAM start-up sequencer top. Walks the fixed start-up command
// order, pads each command with NOPs to its minimum spacing, waits for
// DLL lock and then opens the request path.
// Assumes: all spacings >= 1; PWRUP_CYC >= 1; DLL_LOCK_CYC >= 1.
module ddr_boot_seq
    import ddr_boot_pkg::*;
#(
    parameter int ADDR_W       = 13,
    parameter int PWRUP_CYC    = 40000,
    parameter int T_RP         = 3,
    parameter int T_MRD        = 2,
    parameter int T_RFC        = 15,
    parameter int DLL_LOCK_CYC = 200,
    parameter int BURST_LEN    = 4,
    parameter int CAS_LAT      = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_in,
    output logic              cke,
    output logic [1:0]        cmd_code,
    output logic [1:0]        cmd_ba,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              init_done,
    output logic              req_grant
);
    localparam int M1   = (T_RP > T_MRD) ? T_RP : T_MRD;
    localparam int M2   = (M1 > T_RFC) ? M1 : T_RFC;
    localparam int MAXL = (M2 > PWRUP_CYC) ? M2 : PWRUP_CYC;
    localparam int TW   = $clog2(MAXL + 1);

    if (!(BURST_LEN == 2 || BURST_LEN == 4 || BURST_LEN == 8)) begin : g_bl_bad
        $error("BURST_LEN must be 2, 4 or 8");
    end

    boot_step_e step_q;
    boot_step_e step_nxt;
    logic       first_q;
    logic       span_done;
    logic       dll_locked;
    logic       advance;
    ddr_cmd_e   cmd_e;
    logic [TW-1:0] span_val;

    // Step length minus one, loaded into the span timer on entry
    function automatic logic [TW-1:0] span_of(input boot_step_e s);
        case (s)
            ST_PWR:                 return TW'(PWRUP_CYC - 1);
            ST_PRE1, ST_PRE2:       return TW'(T_RP - 1);
            ST_EMR, ST_MRR, ST_MRF: return TW'(T_MRD - 1);
            ST_REF1, ST_REF2:       return TW'(T_RFC - 1);
            default:                return '0;
        endcase
    endfunction

    // Decide when the current step ends and which step follows
    always_comb begin
        step_nxt = boot_step_e'(step_q + 4'd1);
        case (step_q)
            ST_LOCK: advance = dll_locked;
            ST_DONE: advance = 1'b0;
            default: advance = span_done;
        endcase
        span_val = span_of(step_nxt);
    end

    // Step register and first-cycle flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q  <= ST_PWR;
            first_q <= 1'b1;
        end else if (advance) begin
            step_q  <= step_nxt;
            first_q <= 1'b1;
        end else begin
            first_q <= 1'b0;
        end
    end

    boot_span_timer #(
        .W         (TW),
        .RESET_VAL (PWRUP_CYC - 1)
    ) u_span (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (advance),
        .load_val (span_val),
        .expired  (span_done)
    );

    boot_lock_counter #(
        .LOCK_CYC (DLL_LOCK_CYC)
    ) u_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (step_q == ST_MRR && first_q),
        .locked (dll_locked)
    );

    boot_cmd_decode #(
        .ADDR_W    (ADDR_W),
        .BURST_LEN (BURST_LEN),
        .CAS_LAT   (CAS_LAT)
    ) u_dec (
        .step  (step_q),
        .first (first_q),
        .cmd   (cmd_e),
        .ba    (cmd_ba),
        .addr  (cmd_addr)
    );

    assign cmd_code  = cmd_e;
    assign cke       = (step_q != ST_PWR);
    assign init_done = (step_q == ST_DONE);
    assign req_grant = req_in & init_done;
endmodule

// File: rtl/ddr_boot_seq_chk.sv
`timescale 1ns/1ps
// Property checker for the start-up sequencer, bound to every instance.
// Assumes: all command spacings >= 2 and a single DLL-reset load per reset.
module ddr_boot_seq_chk #(
    parameter int ADDR_W       = 13,
    parameter int DLL_LOCK_CYC = 200
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_in,
    input logic              cke,
    input logic [1:0]        cmd_code,
    input logic [1:0]        cmd_ba,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic              init_done,
    input logic              req_grant
);
    localparam int CW = $clog2(DLL_LOCK_CYC + 1);

    logic [CW-1:0] seen_cnt;

    // Independent count of cycles since the DLL-reset load on the pins
    always_ff @(posedge clk) begin
        if (!rst_n)
            seen_cnt <= '0;
        else if (cmd_code == 2'd2 && cmd_ba == 2'd0 && cmd_addr[8])
            seen_cnt <= CW'(1);
        else if (seen_cnt != '0 && seen_cnt != CW'(DLL_LOCK_CYC))
            seen_cnt <= seen_cnt + 1'b1;
    end

    assert_cke_low_nop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |-> cmd_code == 2'd0);

    assert_cke_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cke |=> cke);

    assert_prea_all_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_code == 2'd1 |-> (cmd_addr[10] && cmd_ba == 2'd0));

    assert_aref_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_code == 2'd3 |-> (cmd_ba == 2'd0 && cmd_addr == '0));

    assert_gap_nop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_code != 2'd0 |=> cmd_code == 2'd0);

    assert_lock_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done) |-> seen_cnt == CW'(DLL_LOCK_CYC));

    assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    assert_grant_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_grant |-> (init_done && req_in));

    assert_quiet_after_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> cmd_code == 2'd0);
endmodule

bind ddr_boot_seq ddr_boot_seq_chk #(
    .ADDR_W       (ADDR_W),
    .DLL_LOCK_CYC (DLL_LOCK_CYC)
) u_boot_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_in    (req_in),
    .cke       (cke),
    .cmd_code  (cmd_code),
    .cmd_ba    (cmd_ba),
    .cmd_addr  (cmd_addr),
    .init_done (init_done),
    .req_grant (req_grant)
);

// File: tb/test_ddr_boot_seq.sv
`timescale 1ns/1ps
// Bench: walks every cycle of three start-up runs on a small configuration
// and compares all outputs with a schedule computed from the requirements.
module test_ddr_boot_seq;
    localparam int AW   = 13;
    localparam int P    = 12;
    localparam int TRP  = 3;
    localparam int TMRD = 2;
    localparam int TRFC = 6;
    localparam int DLL  = 30;
    localparam int BL   = 4;
    localparam int CL   = 3;

    localparam int S_PRE1 = P + 1;
    localparam int S_EMR  = S_PRE1 + TRP;
    localparam int S_MRR  = S_EMR + TMRD;
    localparam int S_PRE2 = S_MRR + TMRD;
    localparam int S_REF1 = S_PRE2 + TRP;
    localparam int S_REF2 = S_REF1 + TRFC;
    localparam int S_MRF  = S_REF2 + TRFC;
    localparam int S_LOCK = S_MRF + TMRD;
    localparam int D_SLOT = ((S_MRR + DLL) > S_LOCK ? (S_MRR + DLL) : S_LOCK) + 1;
    localparam int LAST   = D_SLOT + 10;
    localparam int BLCODE = (BL == 2) ? 1 : (BL == 4) ? 2 : 3;
    localparam int MODE   = (CL << 4) | BLCODE;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_in = 1'b0;
    logic          cke;
    logic [1:0]    cmd_code;
    logic [1:0]    cmd_ba;
    logic [AW-1:0] cmd_addr;
    logic          init_done;
    logic          req_grant;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    ddr_boot_seq #(
        .ADDR_W (AW), .PWRUP_CYC (P), .T_RP (TRP), .T_MRD (TMRD),
        .T_RFC (TRFC), .DLL_LOCK_CYC (DLL), .BURST_LEN (BL), .CAS_LAT (CL)
    ) i_ddr_boot_seq (
        .clk (clk), .rst_n (rst_n), .req_in (req_in), .cke (cke),
        .cmd_code (cmd_code), .cmd_ba (cmd_ba), .cmd_addr (cmd_addr),
        .init_done (init_done), .req_grant (req_grant)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Expected command, bank, address and owning requirement for a slot
    task automatic expect_cmd(input int s, output int c, output int b,
                              output int a, output string tag);
        c = 0; b = 0; a = 0; tag = "R7";
        if (s < P)            tag = "R2";
        else if (s == P)      tag = "R3";
        else if (s == S_PRE1) begin c = 1; a = 1 << 10; tag = "R3"; end
        else if (s == S_EMR)  begin c = 2; b = 1; tag = "R4"; end
        else if (s == S_MRR)  begin c = 2; a = MODE | (1 << 8); tag = "R5"; end
        else if (s == S_PRE2) begin c = 1; a = 1 << 10; tag = "R6"; end
        else if (s == S_REF1 || s == S_REF2) begin c = 3; tag = "R6"; end
        else if (s == S_MRF)  begin c = 2; a = MODE; tag = "R6"; end
    endtask

    // One run: reset, then check every slot; stop early at abort_at if >= 0
    task automatic run_seq(input int run, input int abort_at);
        int c, b, a;
        string tag;
        rst_n = 1'b0;
        req_in = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        chk((run == 0) ? "R1 cke" : "R10 cke", int'(cke), 0);
        chk("R1 cmd", int'(cmd_code), 0);
        chk("R1 done", int'(init_done), 0);
        chk("R1 grant", int'(req_grant), 0);
        rst_n = 1'b1;
        for (int s = 0; s <= LAST; s++) begin
            if (s > 0) @(negedge clk);
            req_in = (((s * 5 + run * 3) % 4) < 2);
            #1;
            expect_cmd(s, c, b, a, tag);
            chk({tag, " cmd"}, int'(cmd_code), c);
            chk({tag, " ba"}, int'(cmd_ba), b);
            chk({tag, " addr"}, int'(cmd_addr), a);
            chk("R2 cke", int'(cke), (s >= P) ? 1 : 0);
            chk("R8 done", int'(init_done), (s >= D_SLOT) ? 1 : 0);
            chk("R9 grant", int'(req_grant),
                (s >= D_SLOT && req_in) ? 1 : 0);
            if (s == abort_at) return;
        end
    endtask

    initial begin
        run_seq(0, -1);
        run_seq(1, S_REF1 + 2);
        run_seq(2, -1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule